// File: doc/BRIEF.md
# Auxiliary Channel Request Header Packer

This block turns one auxiliary-channel transaction request into the byte stream that a display-link auxiliary transmitter sends. A request is made of a 4-bit command, a 20-bit target address, a payload length from 0 to 16 bytes and up to 16 payload bytes. The request is taken in over a valid/ready handshake. The block then puts out a 4-byte header, one byte per accepted output transfer. For a write, the payload bytes follow the header. Requests that are too long, and requests whose command is not a read or write, are taken in and dropped. A one-cycle flag reports each of them, and no byte is sent.

A separate combinational path decodes the result of a finished transaction. It takes a status code, the acknowledge byte, the number of bytes the channel returned and the size that was asked for. From these it gives a result class (success, timeout or I/O error), the reply nibble and a byte count that never exceeds the requested size.

Top module: `auxReqPacker`

## Requirements
- R1: The first three bytes sent are address bits 7:0, then address bits 15:8, then a byte with the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Bits 3:0 of the fourth header byte are the payload length minus one, or 0 when the length is 0.
- R3: Bits 7:4 of the fourth header byte are 3 when the length is 0. Otherwise they are (4 + length) modulo 16 for a write and 4 for a read.
- R4: A command is a write when bit 0 is 0 and a read when bit 0 is 1. A write sends payload byte k, taken from inPayload[8k+7:8k], right after the header, for k = 0 up to length-1. A read sends the 4 header bytes only. outLast is high with the final byte.
- R5: A request with length above 16 is accepted and dropped. errTooLong is high for exactly the cycle after acceptance. No byte is sent and inReady stays high.
- R6: Bit 2 of the command is ignored when it is checked. Any other value outside {0, 1, 8, 9} is accepted and dropped. errBadCmd is high for exactly the cycle after acceptance, and no byte is sent.
- R7: inReady is low from the cycle after a good request is accepted until the final byte has been transferred. It is high again in the cycle that follows.
- R8: While outValid is high and outReady is low, outValid and outData hold their values.
- R9: Status 1 gives rspTimeout, status 2 or 3 gives rspIoErr, and any other status gives rspOk. Exactly one of the three is high.
- R10: On success, rspReply is bits 7:4 of rspAck and rspBytes is the smaller of rspCount and rspReqLen. On any error, both are 0.
- R11: During reset, inReady is high and outValid, errTooLong and errBadCmd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can take a request |
| inCmd | input | 4 | Request command |
| inAddr | input | 20 | Target address |
| inLen | input | 5 | Payload length in bytes |
| inPayload | input | 128 | Payload bytes, byte k in bits 8k+7:8k |
| outValid | output | 1 | Output byte present |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Final byte of the request |
| errTooLong | output | 1 | Pulse: request dropped for length |
| errBadCmd | output | 1 | Pulse: request dropped for command |
| rspStatus | input | 8 | Returned status code |
| rspAck | input | 8 | Returned acknowledge byte |
| rspCount | input | 5 | Bytes returned by the channel |
| rspReqLen | input | 5 | Bytes requested |
| rspTimeout | output | 1 | Result class timeout |
| rspIoErr | output | 1 | Result class I/O error |
| rspOk | output | 1 | Result class success |
| rspReply | output | 4 | Reply nibble |
| rspBytes | output | 5 | Capped returned byte count |

## Verification
The assertions check on every cycle the properties that are local in time. These are: the output holds while stalled, inReady drops after a good acceptance, the flag pulses without output for a dropped request, the first byte after a load is the low address byte, the result class is one-hot, and the capped count stays within the request. Only the bench scenarios can show the full byte order of header and payload. They also cover the nibble values of the fourth header byte, including the modulo-16 wrap for long writes and the fixed 3 for address-only requests, as well as the position of outLast and the return of inReady after the last byte under irregular back-pressure.

// File: rtl/auxReqPkg.sv
package auxReqPkg;
  localparam int ADDR_W     = 20;
  localparam int BYTE_W     = 8;
  localparam int CMD_W      = 4;
  localparam int NIB_W      = 4;
  localparam int MAX_LEN    = 16;
  localparam int HDR_BYTES  = 4;
  localparam int LEN_W      = $clog2(MAX_LEN + 1);
  localparam int IDX_W      = $clog2(HDR_BYTES + MAX_LEN);
  localparam int HDR_SEL_W  = $clog2(HDR_BYTES);
  localparam int PAY_SEL_W  = $clog2(MAX_LEN);
  localparam int STAT_W     = 8;
  localparam int PAY_W      = MAX_LEN * BYTE_W;

  localparam logic [CMD_W-1:0] CMD_CONT_MASK = 4'b0100;
  localparam logic [CMD_W-1:0] CMD_I2C_WR    = 4'h0;
  localparam logic [CMD_W-1:0] CMD_I2C_RD    = 4'h1;
  localparam logic [CMD_W-1:0] CMD_NAT_WR    = 4'h8;
  localparam logic [CMD_W-1:0] CMD_NAT_RD    = 4'h9;
  localparam logic [NIB_W-1:0] ADDR_ONLY_NIB = 4'h3;

  localparam logic [STAT_W-1:0] STAT_TIMEOUT = 8'd1;
  localparam logic [STAT_W-1:0] STAT_FLAGS   = 8'd2;
  localparam logic [STAT_W-1:0] STAT_FAULT   = 8'd3;

  typedef enum logic {ST_IDLE, ST_SEND} stT;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobeT;
endpackage

// File: rtl/auxReqCtrl.sv
module auxReqCtrl
  import auxReqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CMD_W-1:0] inCmd,
  input  logic [LEN_W-1:0] inLen,
  input  logic             outReady,
  input  logic             lastByte,
  output logic             inReady,
  output logic             outValid,
  output ctrlStrobeT       strobe,
  output logic             errTooLong,
  output logic             errBadCmd
);
  stT stateQ;
  logic [CMD_W-1:0] baseCmd;
  logic cmdOk, lenOk, accept;

  assign baseCmd = inCmd & ~CMD_CONT_MASK;
  assign cmdOk   = (baseCmd == CMD_I2C_WR) || (baseCmd == CMD_I2C_RD) ||
                   (baseCmd == CMD_NAT_WR) || (baseCmd == CMD_NAT_RD);
  assign lenOk   = inLen <= LEN_W'(MAX_LEN);
  assign inReady = (stateQ == ST_IDLE);
  assign outValid = (stateQ == ST_SEND);
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.load = accept && cmdOk && lenOk;
    strobe.step = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      errTooLong <= 1'b0;
      errBadCmd  <= 1'b0;
    end else begin
      errTooLong <= accept && !lenOk;
      errBadCmd  <= accept && !cmdOk;
      case (stateQ)
        ST_IDLE: if (strobe.load) stateQ <= ST_SEND;
        ST_SEND: if (strobe.step && lastByte) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R7
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && cmdOk && lenOk) |=> !inReady);

  // R5
  too_long_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !lenOk) |=> (errTooLong && !outValid && inReady));

  // R6
  bad_cmd_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !cmdOk) |=> (errBadCmd && !outValid));
endmodule

// File: rtl/auxReqDatapath.sv
module auxReqDatapath
  import auxReqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [CMD_W-1:0]  inCmd,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [PAY_W-1:0]  inPayload,
  output logic [BYTE_W-1:0] outData,
  output logic              lastByte
);
  logic [BYTE_W-1:0] hdrQ [HDR_BYTES];
  logic [BYTE_W-1:0] payQ [MAX_LEN];
  logic [BYTE_W-1:0] payIn [MAX_LEN];
  logic [BYTE_W-1:0] hdrIn [HDR_BYTES];
  logic [IDX_W-1:0]  idxQ, lastQ, lastIn;
  logic [NIB_W-1:0]  loNib, hiNib;
  logic [PAY_SEL_W-1:0] payIdx;
  logic isWrite;

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_paySplit
    assign payIn[k] = inPayload[k*BYTE_W +: BYTE_W];
  end

  assign isWrite = !inCmd[0];

  always_comb begin
    loNib = (inLen == '0) ? '0 : NIB_W'(inLen - LEN_W'(1));
    if (inLen == '0)
      hiNib = ADDR_ONLY_NIB;
    else if (isWrite)
      hiNib = NIB_W'(HDR_BYTES + int'(inLen));
    else
      hiNib = NIB_W'(HDR_BYTES);
    lastIn = isWrite ? IDX_W'(HDR_BYTES - 1 + int'(inLen)) : IDX_W'(HDR_BYTES - 1);
    hdrIn[0] = inAddr[7:0];
    hdrIn[1] = inAddr[15:8];
    hdrIn[2] = {inCmd, inAddr[19:16]};
    hdrIn[3] = {hiNib, loNib};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      lastQ <= '0;
      for (int i = 0; i < HDR_BYTES; i++) hdrQ[i] <= '0;
      for (int i = 0; i < MAX_LEN; i++) payQ[i] <= '0;
    end else if (strobe.load) begin
      idxQ  <= '0;
      lastQ <= lastIn;
      for (int i = 0; i < HDR_BYTES; i++) hdrQ[i] <= hdrIn[i];
      for (int i = 0; i < MAX_LEN; i++) payQ[i] <= payIn[i];
    end else if (strobe.step) begin
      idxQ <= idxQ + IDX_W'(1);
    end
  end

  assign payIdx   = idxQ[PAY_SEL_W-1:0] - PAY_SEL_W'(HDR_BYTES);
  assign lastByte = (idxQ == lastQ);

  always_comb begin
    if (idxQ < IDX_W'(HDR_BYTES))
      outData = hdrQ[idxQ[HDR_SEL_W-1:0]];
    else
      outData = payQ[payIdx];
  end

  // R1
  first_byte_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (outData == $past(inAddr[7:0])));
endmodule

// File: rtl/auxReplyDecode.sv
module auxReplyDecode
  import auxReqPkg::*;
(
  input  logic [STAT_W-1:0] rspStatus,
  input  logic [BYTE_W-1:0] rspAck,
  input  logic [LEN_W-1:0]  rspCount,
  input  logic [LEN_W-1:0]  rspReqLen,
  output logic              rspTimeout,
  output logic              rspIoErr,
  output logic              rspOk,
  output logic [NIB_W-1:0]  rspReply,
  output logic [LEN_W-1:0]  rspBytes
);
  logic ackLowUnused;
  assign ackLowUnused = ^rspAck[NIB_W-1:0];

  assign rspTimeout = (rspStatus == STAT_TIMEOUT);
  assign rspIoErr   = (rspStatus == STAT_FLAGS) || (rspStatus == STAT_FAULT);
  assign rspOk      = !rspTimeout && !rspIoErr;
  assign rspReply   = rspOk ? rspAck[BYTE_W-1:BYTE_W-NIB_W] : '0;
  assign rspBytes   = !rspOk ? '0 : (rspCount > rspReqLen) ? rspReqLen : rspCount;
endmodule

// File: rtl/auxReqPacker.sv
module auxReqPacker
  import auxReqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CMD_W-1:0]  inCmd,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [PAY_W-1:0]  inPayload,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              errTooLong,
  output logic              errBadCmd,
  input  logic [STAT_W-1:0] rspStatus,
  input  logic [BYTE_W-1:0] rspAck,
  input  logic [LEN_W-1:0]  rspCount,
  input  logic [LEN_W-1:0]  rspReqLen,
  output logic              rspTimeout,
  output logic              rspIoErr,
  output logic              rspOk,
  output logic [NIB_W-1:0]  rspReply,
  output logic [LEN_W-1:0]  rspBytes
);
  ctrlStrobeT strobe;
  logic lastByte;

  auxReqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCmd(inCmd), .inLen(inLen),
    .outReady(outReady), .lastByte(lastByte), .inReady(inReady),
    .outValid(outValid), .strobe(strobe), .errTooLong(errTooLong),
    .errBadCmd(errBadCmd)
  );

  auxReqDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inCmd(inCmd), .inAddr(inAddr),
    .inLen(inLen), .inPayload(inPayload), .outData(outData), .lastByte(lastByte)
  );

  auxReplyDecode u_dec (
    .rspStatus(rspStatus), .rspAck(rspAck), .rspCount(rspCount),
    .rspReqLen(rspReqLen), .rspTimeout(rspTimeout), .rspIoErr(rspIoErr),
    .rspOk(rspOk), .rspReply(rspReply), .rspBytes(rspBytes)
  );

  assign outLast = outValid && lastByte;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R9
  status_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspOk, rspTimeout, rspIoErr}) == 1);

  // R10
  byte_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspBytes <= rspReqLen) && (rspBytes <= rspCount));
endmodule

// File: tb/auxReqPacker_tb.sv
module auxReqPacker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // each entry: {command, address, length}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'h8, 20'h12345, 5'd3},
    {4'h9, 20'hABCDE, 5'd16},
    {4'h0, 20'h00050, 5'd0},
    {4'h5, 20'h0007F, 5'd1},
    {4'h8, 20'h80001, 5'd16},
    {4'h4, 20'hFFFFF, 5'd12},
    {4'h9, 20'h3C3C3, 5'd0},
    {4'h8, 20'h00100, 5'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [3:0] inCmd = '0;
  logic [19:0] inAddr = '0;
  logic [4:0] inLen = '0;
  logic [127:0] inPayload = '0;
  logic outValid, outReady = 1'b0, outLast;
  logic [7:0] outData;
  logic errTooLong, errBadCmd;
  logic [7:0] rspStatus = '0, rspAck = '0;
  logic [4:0] rspCount = '0, rspReqLen = '0;
  logic rspTimeout, rspIoErr, rspOk;
  logic [3:0] rspReply;
  logic [4:0] rspBytes;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  auxReqPacker u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inCmd(inCmd),
    .inAddr(inAddr), .inLen(inLen), .inPayload(inPayload), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .errTooLong(errTooLong), .errBadCmd(errBadCmd), .rspStatus(rspStatus),
    .rspAck(rspAck), .rspCount(rspCount), .rspReqLen(rspReqLen),
    .rspTimeout(rspTimeout), .rspIoErr(rspIoErr), .rspOk(rspOk),
    .rspReply(rspReply), .rspBytes(rspBytes)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [3:0] c, input logic [19:0] a,
                                         input logic [4:0] l, input logic [7:0] seed,
                                         input int k);
    logic [3:0] lo, hi;
    lo = (l == 0) ? 4'h0 : 4'(l - 5'd1);
    hi = (l == 0) ? 4'h3 : (!c[0] ? 4'(4 + int'(l)) : 4'h4);
    case (k)
      0: return a[7:0];
      1: return a[15:8];
      2: return {c, a[19:16]};
      3: return {hi, lo};
      default: return seed + 8'(k - 4);
    endcase
  endfunction

  // R1 R2 R3 R4 R7 R8: one request, irregular back-pressure
  task automatic runReq(input logic [3:0] c, input logic [19:0] a,
                        input logic [4:0] l, input int v);
    int expN, got, cyc;
    logic [7:0] seed, heldData;
    bit heldStall, rdy;
    seed = 8'(v * 16 + 32);
    expN = !c[0] ? 4 + int'(l) : 4;
    inCmd = c; inAddr = a; inLen = l;
    for (int k = 0; k < 16; k++) inPayload[k*8 +: 8] = seed + 8'(k);
    inValid = 1'b1;
    check(inReady == 1'b1, "R7 ready before accept", 32'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R7 busy after accept", 32'(inReady), 0);
    got = 0; cyc = 0; heldStall = 1'b0; heldData = '0;
    while (got < expN && cyc < 200) begin
      if (heldStall)
        check(outValid && outData == heldData, "R8 hold while stalled",
              32'(outData), 32'(heldData));
      check(outValid == 1'b1, "R4 valid during stream", 32'(outValid), 1);
      rdy = ((cyc + v) % 3) != 0;
      outReady = rdy;
      if (outValid && rdy) begin
        check(outData == expByte(c, a, l, seed, got),
              (got < 3) ? "R1 header byte" : (got == 3) ? "R2 R3 fourth byte" : "R4 payload",
              32'(outData), 32'(expByte(c, a, l, seed, got)));
        check(outLast == (got == expN - 1), "R4 last flag", 32'(outLast),
              32'(got == expN - 1));
        if (got < expN - 1)
          check(inReady == 1'b0, "R7 busy mid stream", 32'(inReady), 0);
        got++;
      end
      heldStall = outValid && !rdy;
      heldData = outData;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    outReady = 1'b0;
    check(got == expN, "R4 byte count", 32'(got), 32'(expN));
    check(inReady == 1'b1 && outValid == 1'b0, "R7 ready after last",
          {30'd0, inReady, outValid}, 32'h2);
  endtask

  // R5 R6: dropped request
  task automatic dropReq(input logic [3:0] c, input logic [4:0] l, input bit isLen);
    inCmd = c; inAddr = 20'h0F0F0; inLen = l; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    if (isLen) begin
      check(errTooLong == 1'b1, "R5 length flag", 32'(errTooLong), 1);
      check(inReady == 1'b1, "R5 ready kept", 32'(inReady), 1);
    end else begin
      check(errBadCmd == 1'b1, "R6 command flag", 32'(errBadCmd), 1);
    end
    check(outValid == 1'b0, isLen ? "R5 no output" : "R6 no output", 32'(outValid), 0);
    @(negedge clk);
    check(errTooLong == 1'b0 && errBadCmd == 1'b0, isLen ? "R5 pulse ends" : "R6 pulse ends",
          {30'd0, errTooLong, errBadCmd}, 0);
    check(outValid == 1'b0, isLen ? "R5 still silent" : "R6 still silent", 32'(outValid), 0);
  endtask

  // R9 R10: result decode
  task automatic decodeCase(input logic [7:0] st, input logic [7:0] ack,
                            input logic [4:0] cnt, input logic [4:0] req);
    logic eT, eE, eO;
    logic [3:0] eR;
    logic [4:0] eB;
    eT = (st == 8'd1);
    eE = (st == 8'd2) || (st == 8'd3);
    eO = !eT && !eE;
    eR = eO ? ack[7:4] : 4'h0;
    eB = !eO ? 5'd0 : ((cnt > req) ? req : cnt);
    rspStatus = st; rspAck = ack; rspCount = cnt; rspReqLen = req;
    #1;
    check({rspTimeout, rspIoErr, rspOk} == {eT, eE, eO}, "R9 class",
          {29'd0, rspTimeout, rspIoErr, rspOk}, {29'd0, eT, eE, eO});
    check(rspReply == eR && rspBytes == eB, "R10 reply and count",
          {23'd0, rspReply, rspBytes}, {23'd0, eR, eB});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    check(inReady == 1'b1 && outValid == 1'b0 && errTooLong == 1'b0 && errBadCmd == 1'b0,
          "R11 reset state", {28'd0, inReady, outValid, errTooLong, errBadCmd}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      runReq(VEC[v][28:25], VEC[v][24:5], VEC[v][4:0], v);
      @(negedge clk);
    end

    dropReq(4'h8, 5'd17, 1'b1);
    dropReq(4'h9, 5'd31, 1'b1);
    dropReq(4'h2, 5'd2, 1'b0);
    dropReq(4'hE, 5'd0, 1'b0);
    dropReq(4'hF, 5'd4, 1'b0);
    // a good request right after drops
    runReq(4'hC, 20'h5A5A5, 5'd2, 3);

    decodeCase(8'd0, 8'hA5, 5'd10, 5'd7);
    decodeCase(8'd1, 8'hA5, 5'd3, 5'd7);
    decodeCase(8'd2, 8'hF0, 5'd3, 5'd7);
    decodeCase(8'd3, 8'h70, 5'd3, 5'd7);
    decodeCase(8'd4, 8'h30, 5'd3, 5'd7);
    decodeCase(8'hFF, 8'h20, 5'd16, 5'd16);
    decodeCase(8'd0, 8'h00, 5'd0, 5'd5);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule